// File: doc/BRIEF.md
# Retriggerable Socket Activity Indicator

This block drives an active-high indicator that lights whenever the card socket is busy. A qualified activity event loads a down-counter with a window length, and the output stays high until that window runs out. Every new event reloads the counter, so steady traffic keeps the output on without a gap. When the socket is idle, the output is low.

Activity counts only when a card sits in the socket, has power and is not held in reset. What counts as activity depends on the card type. A 16-bit card signals activity by pulling its combined ready/interrupt line low. A 32-bit card signals activity through any of three active-high strobes: cycle frame, initiator ready or bus request. The activity lines pass through a reset-aware synchronizer.

Three conditions force the output low and clear the window: system suspend, a pending clock-stop request, and the light-sleep power states. The window length is given in clock cycles. The default is 64 ms at a 33 MHz clock.

Top module: `activity_led`

## Requirements
- R1: During reset and in the first cycle after reset, `act_led` is low. With no qualified activity, it stays low.
- R2: With `card_is_32`=0 and the card qualified, a low level on `rdy_irq_n` sampled at one rising edge drives `act_led` high after the third rising edge (SYNC_STAGES=2 synchronizer, then the window register).
- R3: With `card_is_32`=1 and the card qualified, each of `cb_frame_act`, `cb_irdy_act` and `cb_req_act` (active high) can trigger `act_led` on its own, with the same latency as R2.
- R4: After the last qualifying event loads the window, `act_led` stays high for exactly WINDOW_CYCLES cycles and then goes low.
- R5: A qualifying event inside a running window restarts the full WINDOW_CYCLES count from that event.
- R6: An activity level held across many cycles keeps `act_led` high continuously. The output falls WINDOW_CYCLES cycles after the last sampled active level.
- R7: Activity has no effect unless `card_present`=1, `card_powered`=1 and `card_rst_hold`=0 all hold together.
- R8: Only the lines of the selected card type count. A 16-bit card ignores the three 32-bit strobes, and a 32-bit card ignores `rdy_irq_n`.
- R9: `act_led` is low in the cycle after any of these is sampled: `suspend`=1, `clk_stop_req`=1, or `pwr_state` equal to 2'b01 (light sleep 1) or 2'b10 (light sleep 2). The states 2'b00 (full on) and 2'b11 (off) do not cut the output.
- R10: A cut-off condition also empties the window. Once the condition is removed, `act_led` stays low until a new qualifying event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_is_32 | input | 1 | Card type: 0 = 16-bit card, 1 = 32-bit card |
| card_present | input | 1 | A card is inserted |
| card_powered | input | 1 | Socket power is applied |
| card_rst_hold | input | 1 | Card is held in reset |
| rdy_irq_n | input | 1 | 16-bit card ready/interrupt line; low means activity |
| cb_frame_act | input | 1 | 32-bit card cycle frame active |
| cb_irdy_act | input | 1 | 32-bit card initiator ready active |
| cb_req_act | input | 1 | 32-bit card bus request active |
| suspend | input | 1 | System suspend; cuts the output |
| clk_stop_req | input | 1 | Clock is about to be stopped; cuts the output |
| pwr_state | input | 2 | Device power state: 00 full on, 01 and 10 light sleep (cut), 11 off |
| act_led | output | 1 | Registered activity indicator, active high |

## Verification
The assertions assume that the card state, suspend, clock-stop and power-state inputs are already synchronous to `clk`, because they feed the qualification and cut-off logic without a synchronizer. Only the activity lines are allowed to be asynchronous. The bench drives every input on the falling edge, so all of them are stable at each rising edge. It also holds the card state and cut-off inputs steady whenever an activity pulse is still moving through the synchronizer, so that each event is attributed unambiguously to the settings under test.

// File: rtl/activity_led_pkg.sv
package activity_led_pkg;

  typedef enum logic [1:0] {
    PWR_FULL   = 2'b00,
    PWR_LIGHT1 = 2'b01,
    PWR_LIGHT2 = 2'b10,
    PWR_OFF    = 2'b11
  } pwr_state_e;

  // Light-sleep states cut the indicator; full-on and off do not.
  function automatic logic pwr_is_cut(input logic [1:0] st);
    return (st == PWR_LIGHT1) || (st == PWR_LIGHT2);
  endfunction

  // Bit positions inside the synchronized activity vector.
  localparam int ACT_IDX_RDY   = 0;
  localparam int ACT_IDX_FRAME = 1;
  localparam int ACT_IDX_IRDY  = 2;
  localparam int ACT_IDX_REQ   = 3;
  localparam int ACT_LINES     = 4;

endpackage

// File: rtl/act_sync.sv
module act_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= RST_VAL;
          else     stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/act_qualify.sv
module act_qualify
  import activity_led_pkg::*;
(
  input  logic                 card_is_32,
  input  logic                 card_present,
  input  logic                 card_powered,
  input  logic                 card_rst_hold,
  input  logic [ACT_LINES-1:0] act_sync,
  output logic                 hit
);

  logic card_ok;
  logic act16;
  logic act32;

  always_comb begin
    card_ok = card_present && card_powered && !card_rst_hold;
    act16   = !act_sync[ACT_IDX_RDY];
    act32   = act_sync[ACT_IDX_FRAME] || act_sync[ACT_IDX_IRDY] ||
              act_sync[ACT_IDX_REQ];
    hit     = card_ok && (card_is_32 ? act32 : act16);
  end

endmodule

// File: rtl/act_cutoff.sv
module act_cutoff
  import activity_led_pkg::*;
(
  input  logic       suspend,
  input  logic       clk_stop_req,
  input  logic [1:0] pwr_state,
  output logic       cut
);

  always_comb begin
    cut = suspend || clk_stop_req || pwr_is_cut(pwr_state);
  end

endmodule

// File: rtl/act_window.sv
module act_window #(
  parameter int WINDOW_CYCLES = 2_112_000,
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic cut,
  output logic led
);

  logic [CNT_W-1:0] remain_q;
  logic             led_q;

  always_ff @(posedge clk) begin
    if (rst || cut) begin
      remain_q <= '0;
      led_q    <= 1'b0;
    end else if (hit) begin
      remain_q <= CNT_W'(WINDOW_CYCLES - 1);
      led_q    <= 1'b1;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
      led_q    <= 1'b1;
    end else begin
      led_q    <= 1'b0;
    end
  end

  assign led = led_q;

endmodule

// File: rtl/activity_led.sv
module activity_led
  import activity_led_pkg::*;
#(
  parameter int WINDOW_CYCLES = 2_112_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       card_is_32,
  input  logic       card_present,
  input  logic       card_powered,
  input  logic       card_rst_hold,
  input  logic       rdy_irq_n,
  input  logic       cb_frame_act,
  input  logic       cb_irdy_act,
  input  logic       cb_req_act,
  input  logic       suspend,
  input  logic       clk_stop_req,
  input  logic [1:0] pwr_state,
  output logic       act_led
);

  localparam logic [ACT_LINES-1:0] SYNC_RST = ACT_LINES'(1) << ACT_IDX_RDY;

  logic [ACT_LINES-1:0] act_raw;
  logic [ACT_LINES-1:0] act_s;
  logic                 qual_hit;
  logic                 cut_now;

  always_comb begin
    act_raw                = '0;
    act_raw[ACT_IDX_RDY]   = rdy_irq_n;
    act_raw[ACT_IDX_FRAME] = cb_frame_act;
    act_raw[ACT_IDX_IRDY]  = cb_irdy_act;
    act_raw[ACT_IDX_REQ]   = cb_req_act;
  end

  act_sync #(
    .WIDTH  (ACT_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(act_raw),
    .q_sync (act_s)
  );

  act_qualify u_qual (
    .card_is_32   (card_is_32),
    .card_present (card_present),
    .card_powered (card_powered),
    .card_rst_hold(card_rst_hold),
    .act_sync     (act_s),
    .hit          (qual_hit)
  );

  act_cutoff u_cut (
    .suspend     (suspend),
    .clk_stop_req(clk_stop_req),
    .pwr_state   (pwr_state),
    .cut         (cut_now)
  );

  act_window #(
    .WINDOW_CYCLES(WINDOW_CYCLES)
  ) u_win (
    .clk(clk),
    .rst(rst),
    .hit(qual_hit),
    .cut(cut_now),
    .led(act_led)
  );

endmodule

// File: rtl/activity_led_chk.sv
module activity_led_chk #(
  parameter int WINDOW_CYCLES = 2_112_000
) (
  input logic       clk,
  input logic       rst,
  input logic       suspend,
  input logic       clk_stop_req,
  input logic [1:0] pwr_state,
  input logic       hit,
  input logic       act_led
);

  localparam int CW = $clog2(WINDOW_CYCLES + 1);

  logic          cut_seen;
  logic [CW-1:0] since_q;

  assign cut_seen = suspend || clk_stop_req ||
                    (pwr_state == 2'b01) || (pwr_state == 2'b10);

  // Cycles since the last accepted event, saturating at the window length.
  always_ff @(posedge clk) begin
    if (rst)                          since_q <= CW'(WINDOW_CYCLES);
    else if (hit && !cut_seen)        since_q <= '0;
    else if (since_q != CW'(WINDOW_CYCLES)) since_q <= since_q + 1'b1;
  end

  assert_low_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !act_led);

  assert_event_lights_R5: assert property (@(posedge clk) disable iff (rst)
    (hit && !cut_seen) |=> act_led);

  assert_window_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (since_q == CW'(WINDOW_CYCLES)) |-> !act_led);

  assert_rise_needs_event_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(act_led) |-> $past(hit));

  assert_cutoff_low_R9: assert property (@(posedge clk) disable iff (rst)
    cut_seen |=> !act_led);

endmodule

bind activity_led activity_led_chk #(
  .WINDOW_CYCLES(WINDOW_CYCLES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .suspend     (suspend),
  .clk_stop_req(clk_stop_req),
  .pwr_state   (pwr_state),
  .hit         (qual_hit),
  .act_led     (act_led)
);

// File: tb/test_activity_led.sv
module test_activity_led;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 20;
  localparam int LAT        = 3;

  logic       clk = 1'b0;
  logic       rst;
  logic       card_is_32, card_present, card_powered, card_rst_hold;
  logic       rdy_irq_n, cb_frame_act, cb_irdy_act, cb_req_act;
  logic       suspend, clk_stop_req;
  logic [1:0] pwr_state;
  logic       act_led;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  activity_led #(
    .WINDOW_CYCLES(WIN),
    .SYNC_STAGES  (2)
  ) i_activity_led (
    .clk(clk), .rst(rst),
    .card_is_32(card_is_32), .card_present(card_present),
    .card_powered(card_powered), .card_rst_hold(card_rst_hold),
    .rdy_irq_n(rdy_irq_n), .cb_frame_act(cb_frame_act),
    .cb_irdy_act(cb_irdy_act), .cb_req_act(cb_req_act),
    .suspend(suspend), .clk_stop_req(clk_stop_req),
    .pwr_state(pwr_state), .act_led(act_led)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: act_led actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic defaults();
    card_is_32 = 1'b0; card_present = 1'b1; card_powered = 1'b1;
    card_rst_hold = 1'b0; rdy_irq_n = 1'b1; cb_frame_act = 1'b0;
    cb_irdy_act = 1'b0; cb_req_act = 1'b0; suspend = 1'b0;
    clk_stop_req = 1'b0; pwr_state = 2'b00;
  endtask

  task automatic idle();
    tick(WIN + 6);
  endtask

  // sel: 0 rdy_irq_n, 1 frame, 2 irdy, 3 req; one-cycle pulse.
  task automatic pulse(input int sel);
    case (sel)
      0: rdy_irq_n = 1'b0;
      1: cb_frame_act = 1'b1;
      2: cb_irdy_act = 1'b1;
      default: cb_req_act = 1'b1;
    endcase
    tick(1);
    rdy_irq_n = 1'b1; cb_frame_act = 1'b0; cb_irdy_act = 1'b0; cb_req_act = 1'b0;
  endtask

  task automatic t_reset();
    defaults();
    rst = 1'b1;
    tick(3);
    check(act_led, 1'b0, "R1 in reset");
    rst = 1'b0;
    tick(1);
    check(act_led, 1'b0, "R1 after reset");
    tick(10);
    check(act_led, 1'b0, "R1 idle");
  endtask

  task automatic t_16bit_window();
    defaults();
    pulse(0);
    tick(LAT - 2);
    check(act_led, 1'b0, "R2 before latency");
    tick(1);
    check(act_led, 1'b1, "R2 lit after latency");
    tick(WIN - 1);
    check(act_led, 1'b1, "R4 last window cycle");
    tick(1);
    check(act_led, 1'b0, "R4 window expired");
    idle();
  endtask

  task automatic t_32bit();
    for (int s = 1; s <= 3; s++) begin
      defaults();
      card_is_32 = 1'b1;
      pulse(s);
      tick(LAT - 1);
      check(act_led, 1'b1, $sformatf("R3 strobe %0d", s));
      idle();
    end
  endtask

  task automatic t_retrigger();
    defaults();
    pulse(0);
    tick(LAT - 1);
    tick(WIN - 5);
    pulse(0);
    tick(LAT - 1);
    tick(WIN - 2);
    check(act_led, 1'b1, "R5 high past first expiry");
    tick(1);
    check(act_led, 1'b1, "R5 restarted window last cycle");
    tick(1);
    check(act_led, 1'b0, "R5 restarted window expired");
    idle();
  endtask

  task automatic t_held();
    bit bad;
    defaults();
    rdy_irq_n = 1'b0;
    tick(LAT);
    bad = 1'b0;
    for (int i = 0; i < 3 * WIN; i++) begin
      if (act_led !== 1'b1) bad = 1'b1;
      tick(1);
    end
    check(!bad, 1'b1, "R6 continuous while held");
    rdy_irq_n = 1'b1;
    tick(LAT - 1 + WIN - 1);
    check(act_led, 1'b1, "R6 tail last cycle");
    tick(1);
    check(act_led, 1'b0, "R6 tail expired");
    idle();
  endtask

  task automatic t_qualify();
    for (int q = 0; q < 3; q++) begin
      defaults();
      if (q == 0) card_present = 1'b0;
      if (q == 1) card_powered = 1'b0;
      if (q == 2) card_rst_hold = 1'b1;
      pulse(0);
      tick(LAT - 1);
      check(act_led, 1'b0, $sformatf("R7 disqualifier %0d", q));
      tick(2);
      check(act_led, 1'b0, $sformatf("R7 disqualifier %0d later", q));
      tick(5);
    end
    defaults();
  endtask

  task automatic t_type_select();
    defaults();
    card_is_32 = 1'b0;
    cb_frame_act = 1'b1; cb_irdy_act = 1'b1; cb_req_act = 1'b1;
    tick(LAT + 2);
    check(act_led, 1'b0, "R8 16-bit ignores 32-bit strobes");
    defaults();
    tick(LAT);
    card_is_32 = 1'b1;
    rdy_irq_n = 1'b0;
    tick(LAT + 2);
    check(act_led, 1'b0, "R8 32-bit ignores rdy_irq_n");
    defaults();
    tick(LAT + 2);
  endtask

  // kind: 0 suspend, 1 clock stop, 2 light1, 3 light2, 4 off (no cut)
  task automatic t_cutoff();
    for (int k = 0; k < 5; k++) begin
      logic exp;
      defaults();
      exp = (k == 4);
      pulse(0);
      tick(LAT - 1);
      case (k)
        0: suspend = 1'b1;
        1: clk_stop_req = 1'b1;
        2: pwr_state = 2'b01;
        3: pwr_state = 2'b10;
        default: pwr_state = 2'b11;
      endcase
      tick(1);
      check(act_led, exp, $sformatf("R9 cut kind %0d", k));
      defaults();
      tick(2);
      check(act_led, exp, $sformatf("R10 after cut kind %0d", k));
      idle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_16bit_window();
    t_32bit();
    t_retrigger();
    t_held();
    t_qualify();
    t_type_select();
    t_cutoff();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule